// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a digitized three-level half-bridge request into the high-side (`gh`) and low-side (`gl`) gate commands of a synchronous buck stage. A low request turns on the low side. A high request turns on the high side. A mid-window request that persists long enough shuts both gates. Every delay is a parameter counted in clock cycles. All inputs are sampled on the rising edge of the clock.

Dead time is adaptive. After the high side is turned off, the low side waits for one of two flags: the switch node has fallen below about 1 V, or the high-side gate-source voltage has fallen below about 1 V. It then waits a fixed delay before turning on. After the low side is turned off, the high side waits for a low-side gate-discharge flag or for a timeout.

Several conditions force the gates off. A filtered active-low disable shuts both gates, and so do a logic-supply undervoltage flag and a bootstrap undervoltage flag. An active-low skip input suppresses only the low side.

Top module: `gate_seq`

## Requirements
- R1: Request encoding is `ctl` = 2'b00 low, 2'b01 high, 2'b10 or 2'b11 mid-window. A steady low request gives `gl`=1, `gh`=0. A steady high request gives `gh`=1, `gl`=0.
- R2: Reset state: `gh`=0, `gl`=0, `mode`=0 (shutdown), and the enable filter is off. From shutdown the block moves only to low-side-on, after EXIT_DLY consecutive low samples, or to the tri-state-off mode, on one mid sample. It never moves directly to high-side-on.
- R3: In high-side-on, `gh` drops only after HS_OFF_DLY consecutive low samples. A shorter low excursion leaves `gh` high.
- R4: After `gh` is off, `gl` rises on the LS_ON_DLY-th edge, counting from the first edge at which `sw_low` or `hs_vgs_low` is sampled high. Either flag alone is enough. A high request before that point returns directly to high-side-on.
- R5: On a high request, `gl` goes low first. `gh` rises on a later edge at which `ls_vgs_low` is sampled high, or after LS_OFF_TMO samples. `gh` and `gl` are never high in the same cycle.
- R6: A high request in low-side-on is accepted only if the preceding MIN_OFF samples were all low. Otherwise that high pulse is discarded and `gl` stays high.
- R7: A mid-window request drops `gh` after TRI_GH_DLY consecutive mid samples and `gl` after TRI_GL_DLY consecutive mid samples. A shorter mid excursion has no effect on the gates.
- R8: From tri-state-off, EXIT_DLY consecutive valid samples turn on the gate that matches the last sampled level.
- R9: A change of `dis_n` takes effect only after DIS_DLY consecutive samples of the new value. While disabled, both gates are low. Re-enabling starts from shutdown.
- R10: While `skip_n`=0, `gl` is 0 and `gh` still follows the request.
- R11: `uv_logic`=1 forces both gates low in the same cycle. `uv_boot`=1 forces `gh` low in the same cycle. Either flag, when sampled, puts the block in shutdown.
- R12: `mode` reports 0 shutdown, 1 low-side-on, 2 low-side turning off, 3 high-side-on, 4 high-side turning off, 5 tri-state-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl | input | 2 | Digitized three-level request |
| dis_n | input | 1 | Active-low disable |
| skip_n | input | 1 | Active-low low-side suppression |
| uv_logic | input | 1 | Logic-supply undervoltage flag |
| uv_boot | input | 1 | Bootstrap undervoltage flag |
| sw_low | input | 1 | Switch node below about 1 V |
| hs_vgs_low | input | 1 | High-side gate-source voltage below about 1 V |
| ls_vgs_low | input | 1 | Low-side gate discharged |
| gh | output | 1 | High-side gate command |
| gl | output | 1 | Low-side gate command |
| mode | output | 3 | Current mode code |

## Verification
The main switching path is tried with several patterns:
- Clean low/high alternation.
- Low excursions that are too short, which separate the turn-off delay from an immediate response.
- High pulses that follow too short an off time, which show the minimum-off filter.
- Separate turn-offs where only the switch-node flag rises, only the gate-source flag rises, or the low-side discharge flag is withheld.

These separate the two dead-time paths from the timeout. Mid-window excursions both shorter and longer than each hold-off show that the two gate hold-offs are distinct. Disable glitches, skip, and both undervoltage flags are applied while each gate is on, so that the same-cycle and next-edge effects can be told apart.

// File: rtl/gate_seq.sv
module gate_seq #(
  parameter int HS_OFF_DLY = 5,
  parameter int LS_ON_DLY  = 5,
  parameter int LS_OFF_TMO = 4,
  parameter int TRI_GH_DLY = 21,
  parameter int TRI_GL_DLY = 38,
  parameter int DIS_DLY    = 5,
  parameter int EXIT_DLY   = 4,
  parameter int MIN_OFF    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ctl,
  input  logic       dis_n,
  input  logic       skip_n,
  input  logic       uv_logic,
  input  logic       uv_boot,
  input  logic       sw_low,
  input  logic       hs_vgs_low,
  input  logic       ls_vgs_low,
  output logic       gh,
  output logic       gl,
  output logic [2:0] mode
);
  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CMAX = maxi(maxi(maxi(HS_OFF_DLY, LS_ON_DLY), maxi(LS_OFF_TMO, TRI_GL_DLY)),
                             maxi(maxi(DIS_DLY, EXIT_DLY), maxi(MIN_OFF, TRI_GH_DLY)));
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    ST_OFF = 3'd0, ST_LO = 3'd1, ST_LH = 3'd2, ST_HI = 3'd3, ST_HL = 3'd4, ST_TRI = 3'd5
  } st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n, tcnt, tcnt_n, lrun, dcnt;
  logic act;

  wire is_lo  = (ctl == 2'b00);
  wire is_hi  = (ctl == 2'b01);
  wire is_mid = ctl[1];
  wire kill   = uv_logic | uv_boot | ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      dcnt <= '0;
    end else if (dis_n == act) begin
      dcnt <= '0;
    end else if (dcnt == CW'(DIS_DLY - 1)) begin
      act  <= dis_n;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lrun <= '0;
    else if (!is_lo)         lrun <= '0;
    else if (lrun != CW'(MIN_OFF)) lrun <= lrun + CW'(1);
  end

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    tcnt_n = '0;
    if (kill) begin
      st_n  = ST_OFF;
      cnt_n = '0;
    end else begin
      case (st)
        ST_OFF: begin
          if (is_mid) begin
            st_n  = ST_TRI;
            cnt_n = '0;
          end else if (is_lo) begin
            if (cnt == CW'(EXIT_DLY - 1)) begin
              st_n  = ST_LO;
              cnt_n = '0;
            end else cnt_n = cnt + CW'(1);
          end else cnt_n = '0;
        end
        ST_TRI: begin
          if (is_mid) cnt_n = '0;
          else if (cnt == CW'(EXIT_DLY - 1)) begin
            st_n  = is_lo ? ST_LO : ST_HI;
            cnt_n = '0;
          end else cnt_n = cnt + CW'(1);
        end
        default: begin
          if (is_mid) begin
            if (tcnt == CW'(TRI_GL_DLY - 1)) begin
              st_n  = ST_TRI;
              cnt_n = '0;
            end else begin
              tcnt_n = tcnt + CW'(1);
              if (st == ST_HI && tcnt == CW'(TRI_GH_DLY - 1)) begin
                st_n  = ST_HL;
                cnt_n = '0;
              end
            end
          end else begin
            case (st)
              ST_LO: if (is_hi && lrun == CW'(MIN_OFF)) begin
                st_n  = ST_LH;
                cnt_n = '0;
              end
              ST_LH: begin
                if (is_lo) begin
                  st_n  = ST_LO;
                  cnt_n = '0;
                end else if (ls_vgs_low || cnt == CW'(LS_OFF_TMO - 1)) begin
                  st_n  = ST_HI;
                  cnt_n = '0;
                end else cnt_n = cnt + CW'(1);
              end
              ST_HI: begin
                if (!is_lo) cnt_n = '0;
                else if (cnt == CW'(HS_OFF_DLY - 1)) begin
                  st_n  = ST_HL;
                  cnt_n = '0;
                end else cnt_n = cnt + CW'(1);
              end
              ST_HL: begin
                if (is_hi) begin
                  st_n  = ST_HI;
                  cnt_n = '0;
                end else if (cnt != '0 || sw_low || hs_vgs_low) begin
                  if (cnt == CW'(LS_ON_DLY - 1)) begin
                    st_n  = ST_LO;
                    cnt_n = '0;
                  end else cnt_n = cnt + CW'(1);
                end
              end
              default: st_n = ST_OFF;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      cnt  <= '0;
      tcnt <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      tcnt <= tcnt_n;
    end
  end

  assign gh   = act & ~uv_logic & ~uv_boot & (st == ST_HI);
  assign gl   = act & ~uv_logic & skip_n & (st == ST_LO);
  assign mode = st;
endmodule

// File: rtl/gate_seq_sva.sv
module gate_seq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       skip_n,
  input logic       uv_logic,
  input logic       uv_boot,
  input logic       gh,
  input logic       gl,
  input logic [2:0] mode
);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n) !(gh && gl));
  assert_uv_logic_off_R11: assert property (@(posedge clk) disable iff (!rst_n) uv_logic |-> (!gh && !gl));
  assert_uv_boot_gh_R11: assert property (@(posedge clk) disable iff (!rst_n) uv_boot |-> !gh);
  assert_uv_to_off_R11: assert property (@(posedge clk) disable iff (!rst_n) (uv_logic || uv_boot) |=> (mode == 3'd0));
  assert_skip_gl_R10: assert property (@(posedge clk) disable iff (!rst_n) !skip_n |-> !gl);
  assert_off_not_hs_R2: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd0) |=> (mode != 3'd3));
  assert_hs_dead_time_R4: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd3) |=> (mode != 3'd1));
  assert_ls_dead_time_R5: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd1) |=> (mode != 3'd3));
  assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n) mode <= 3'd5);
endmodule

bind gate_seq gate_seq_sva u_sva (.*);

// File: tb/gate_seq_tb.sv
module gate_seq_tb;
  localparam int P_HSOFF = 5, P_LSON = 5, P_TMO = 4, P_TGH = 21, P_TGL = 38;
  localparam int P_DIS = 5, P_EXIT = 4, P_MINOFF = 16;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, MID = 2'b10;

  logic clk = 0, rst_n = 0;
  logic [1:0] ctl = MID;
  logic dis_n = 1, skip_n = 1, uv_logic = 0, uv_boot = 0;
  logic sw_low = 0, hs_vgs_low = 0, ls_vgs_low = 1;
  logic gh, gl;
  logic [2:0] mode;
  int compared = 0, mismatched = 0;
  bit done = 0;
  string req = "R2";

  always #2 clk = ~clk;

  gate_seq #(.HS_OFF_DLY(P_HSOFF), .LS_ON_DLY(P_LSON), .LS_OFF_TMO(P_TMO), .TRI_GH_DLY(P_TGH),
             .TRI_GL_DLY(P_TGL), .DIS_DLY(P_DIS), .EXIT_DLY(P_EXIT), .MIN_OFF(P_MINOFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .dis_n(dis_n), .skip_n(skip_n), .uv_logic(uv_logic),
    .uv_boot(uv_boot), .sw_low(sw_low), .hs_vgs_low(hs_vgs_low), .ls_vgs_low(ls_vgs_low),
    .gh(gh), .gl(gl), .mode(mode));

  // behavioural model: m_md holds the mode code of R12
  int m_md = 0, m_wait = 0, m_mid = 0, m_lows = 0, m_on = 0, m_glitch = 0;

  always @(posedge clk or negedge rst_n) begin
    int nm, nw, nmid;
    if (!rst_n) begin
      m_md = 0; m_wait = 0; m_mid = 0; m_lows = 0; m_on = 0; m_glitch = 0;
    end else begin
      nm = m_md; nw = m_wait; nmid = 0;
      if (uv_logic || uv_boot || m_on == 0) begin
        nm = 0; nw = 0;
      end else if (m_md == 0 && ctl[1]) begin
        nm = 5; nw = 0;
      end else if (m_md == 0) begin
        nw = (ctl == LO) ? m_wait + 1 : 0;
        if (nw == P_EXIT) begin nm = 1; nw = 0; end
      end else if (m_md == 5) begin
        nw = ctl[1] ? 0 : m_wait + 1;
        if (nw == P_EXIT) begin nm = (ctl == LO) ? 1 : 3; nw = 0; end
      end else if (ctl[1]) begin
        nmid = m_mid + 1;
        if (nmid == P_TGL) begin nm = 5; nw = 0; nmid = 0; end
        else if (m_md == 3 && nmid == P_TGH) begin nm = 4; nw = 0; end
      end else if (m_md == 1) begin
        if (ctl == HI && m_lows >= P_MINOFF) begin nm = 2; nw = 0; end
      end else if (m_md == 2) begin
        if (ctl == LO) begin nm = 1; nw = 0; end
        else if (ls_vgs_low || m_wait + 1 == P_TMO) begin nm = 3; nw = 0; end
        else nw = m_wait + 1;
      end else if (m_md == 3) begin
        nw = (ctl == LO) ? m_wait + 1 : 0;
        if (nw == P_HSOFF) begin nm = 4; nw = 0; end
      end else if (m_md == 4) begin
        if (ctl == HI) begin nm = 3; nw = 0; end
        else if (m_wait > 0 || sw_low || hs_vgs_low) begin
          nw = m_wait + 1;
          if (nw == P_LSON) begin nm = 1; nw = 0; end
        end
      end
      m_lows = (ctl == LO) ? m_lows + 1 : 0;
      if ((dis_n ? 1 : 0) != m_on) begin
        m_glitch++;
        if (m_glitch == P_DIS) begin m_on = dis_n; m_glitch = 0; end
      end else m_glitch = 0;
      m_md = nm; m_wait = nw; m_mid = nmid;
    end
  end

  task automatic compare();
    logic egh, egl;
    egh = (m_on != 0) && !uv_logic && !uv_boot && m_md == 3;
    egl = (m_on != 0) && !uv_logic && skip_n && m_md == 1;
    compared++;
    if (gh !== egh || gl !== egl || mode !== 3'(m_md)) begin
      mismatched++;
      $display("FAIL %s t=%0t gh/gl/mode actual=%b/%b/%0d expected=%b/%b/%0d",
               req, $time, gh, gl, mode, egh, egl, m_md);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    run(3);
    compared++;
    if (gh !== 1'b0 || gl !== 1'b0 || mode !== 3'd0) begin
      mismatched++;
      $display("FAIL R2 reset actual=%b/%b/%0d expected=0/0/0", gh, gl, mode);
    end
    rst_n = 1;
    req = "R2"; ctl = HI; run(20);
    req = "R1"; ctl = LO; run(30);
    req = "R1"; ctl = HI; run(20);
    req = "R3"; ctl = LO; run(2); ctl = HI; run(5);
    req = "R4"; ctl = LO; run(10); sw_low = 1; run(10); sw_low = 0;
    req = "R4"; ctl = HI; run(20); ctl = LO; hs_vgs_low = 1; run(15); hs_vgs_low = 0;
    req = "R4"; ctl = HI; run(10); ctl = LO; run(7); ctl = HI; run(6);
    req = "R6"; ctl = LO; sw_low = 1; run(20); ctl = HI; run(3); ctl = LO; run(5); ctl = HI; run(3);
    ctl = LO; run(20);
    req = "R5"; ls_vgs_low = 0; ctl = HI; run(10); ls_vgs_low = 1; ctl = LO; run(20);
    req = "R7"; ctl = MID; run(10); ctl = LO; run(5); ctl = MID; run(50);
    req = "R8"; ctl = HI; run(10);
    req = "R7"; ctl = MID; run(25); ctl = LO; run(20);
    req = "R8"; ctl = MID; run(40); ctl = LO; run(10);
    req = "R10"; skip_n = 0; run(5); ctl = HI; run(20); ctl = LO; run(20); skip_n = 1; run(5);
    req = "R9"; dis_n = 0; run(3); dis_n = 1; run(5); dis_n = 0; run(10); dis_n = 1; ctl = HI; run(20);
    ctl = LO; run(20);
    req = "R11"; uv_boot = 1; run(3); uv_boot = 0; run(10); ctl = HI; run(20);
    uv_logic = 1; run(2); uv_logic = 0; run(3); ctl = MID; run(5); ctl = HI; run(10);
    uv_boot = 1; run(2); uv_boot = 0; ctl = LO; run(30);
    req = "R12"; ctl = 2'b11; run(45); ctl = LO; run(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule